// File: doc/BRIEF.md
# Clause 45 MDIO Frame Engine

This block is a management-bus master. The host hands it one pre-packed 32-bit frame word and a start strobe. The engine then puts the frame out serially on a management clock and data pair: a run of ones as preamble first, then the word most significant bit first. Reads and post-read-increment frames differ from address and write frames. The master lets go of the data line at the first turnaround bit. It then samples the 16 data bits that the PHY returns and presents them on `rdata_o`.

The frame word has a fixed layout. Bits 31:30 hold the start code (00 for Clause 45). Bits 29:28 hold the opcode: 00 address, 01 write, 11 read, 10 post-read-increment. Bits 27:23 hold the port address and bits 22:18 the device address. Bits 17:16 are the turnaround and bits 15:0 carry the address or data. A register access is an address frame that carries the register offset, followed by a write or read frame to the same port and device. The host computes the port address as a platform base plus the port number and packs it into the word.

The controller is a state machine with six states:
- `S_IDLE`: the line is released and MDC is held low.
- `S_PREAMBLE`: the ones are driven.
- `S_HEADER`: start code, opcode, port address and device address are sent.
- `S_TURN`: the two turnaround bits.
- `S_DATA`: the 16 data bits.
- `S_TAIL`: the last MDC high phase is allowed to complete.

The transitions are:
- start-accept: `S_IDLE` to `S_PREAMBLE`.
- preamble-done: to `S_HEADER` on the falling edge after the last preamble bit.
- header-done: to `S_TURN` after the 14th header bit.
- turn-done: to `S_DATA` after the second turnaround bit.
- last-sample: to `S_TAIL` on the MDC rising edge of the final data bit.
- tail-done: to `S_IDLE` on the next MDC falling edge.

Top module: `mdio_frame_master`

## Requirements
- R1: Out of reset, and whenever idle, `busy_o`=0, `done_o`=0, `mdc_o`=0 and `mdio_oe_o`=0 (line released).
- R2: MDC is low while idle. Each MDC phase, high or low, lasts `HALF_DIV` system clocks, and the first rising edge comes `HALF_DIV` clocks after the start is accepted. `mdio_o` changes only while MDC is low, so a frame holds MDC high for exactly 64×`HALF_DIV` clocks.
- R3: Each frame is 32 ones of preamble followed by the 32 frame bits, bit 31 first. That makes 64 MDC rising edges per frame.
- R4: For opcodes 00 (address) and 01 (write), the master drives all 64 bits. It sends the turnaround as 1 then 0, whatever word bits 17:16 hold.
- R5: For opcodes 11 (read) and 10 (post-read-increment), identified by word bit 29 = 1, the master releases the line (`mdio_oe_o`=0) from the first turnaround bit to the end of the frame. Word bits 15:0 are never driven.
- R6: On a read or post-read frame, the 16 bits seen on `mdio_i` at the data-phase MDC rising edges are captured MSB first into `rdata_o`. Address and write frames leave `rdata_o` unchanged.
- R7: `busy_o` rises on the clock edge that accepts the start. It falls 128×`HALF_DIV` clocks after that edge, on the MDC falling edge that ends the last bit.
- R8: `done_o` is a single-clock pulse. It becomes visible on the edge 127×`HALF_DIV` clocks after the accepting edge, one clock after the final data sample. `rdata_o` is valid at that point and `busy_o` is still high.
- R9: A start strobe while `busy_o`=1 is ignored. The frame in progress goes out unchanged and only one `done_o` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| frame_i | input | 32 | Packed frame word, sampled with the start |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Data captured by the last read or post-read frame |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven onto the line |
| mdio_oe_o | output | 1 | Drive enable for the data line; 0 releases it |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
The hardest case to reach is the handover of the line during a read turnaround. The master must already be released on the first turnaround bit. The PHY must drive a zero on the second bit, and the data bits must line up with the MDC rising edges. The bench models the PHY behaviourally. It counts MDC rising edges and changes its own drive on each MDC falling edge. The pad value is resolved as the master's bit when enabled and the PHY's otherwise, so a wrong release point or a one-bit capture slip shows up in the sampled frame and in `rdata_o`. A second start strobe is injected halfway through the preamble of a frame, to show that it neither corrupts nor restarts the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREAMBLE,
        S_HEADER,
        S_TURN,
        S_DATA,
        S_TAIL
    } mdio_state_e;

    localparam int FRAME_W   = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int OP_RD_BIT = 29;

    // Opcodes 11 and 10 both hand the line to the PHY after the header.
    function automatic logic op_is_read(input logic [FRAME_W-1:0] w);
        return w[OP_RD_BIT];
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_o <= ~mdc_o;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign rise_o = run_i && wrap && !mdc_o;
    assign fall_o = run_i && wrap &&  mdc_o;

    // R2: MDC parks low whenever the engine is not running
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_o);

endmodule

// File: rtl/mdio_tx_mux.sv
module mdio_tx_mux
    import mdio_pkg::*;
(
    input  mdio_state_e        state_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [4:0]         fidx_i,
    output logic               bit_o,
    output logic               oe_o
);
    logic rd;
    logic word_bit;

    assign rd       = op_is_read(frame_i);
    assign word_bit = frame_i[5'(FRAME_W - 1) - fidx_i];

    always_comb begin
        bit_o = 1'b1;
        oe_o  = 1'b1;
        unique case (state_i)
            S_IDLE:     oe_o = 1'b0;
            S_PREAMBLE: bit_o = 1'b1;
            S_HEADER:   bit_o = word_bit;
            S_TURN: begin
                if (rd) oe_o = 1'b0;
                else    bit_o = (fidx_i == 5'(HDR_BITS));
            end
            S_DATA, S_TAIL: begin
                if (rd) oe_o = 1'b0;
                else    bit_o = word_bit;
            end
            default:    oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)       q_o <= '0;
        else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
    end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] frame_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    localparam int POS_W = $clog2(PRE_LEN + FRAME_W);

    mdio_state_e          state_q, state_d;
    logic [POS_W-1:0]     pos_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [4:0]           fidx;
    logic                 rise, fall, rd, last_bit;
    logic [DATA_BITS-1:0] cap_q;

    assign busy_o   = (state_q != S_IDLE);
    assign rd       = op_is_read(frame_q);
    assign fidx     = 5'(pos_q - POS_W'(PRE_LEN));
    assign last_bit = (state_q == S_DATA) && (fidx == 5'(FRAME_W - 1));

    mdio_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .mdc_o  (mdc_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_tx_mux u_tx (
        .state_i (state_q),
        .frame_i (frame_q),
        .fidx_i  (fidx),
        .bit_o   (mdio_o),
        .oe_o    (mdio_oe_o)
    );

    mdio_rx_shift #(.W(DATA_BITS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (rise && rd && (state_q == S_DATA)),
        .bit_i   (mdio_i),
        .q_o     (cap_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: start-accept, preamble-done, header-done, turn-done,
    // last-sample, tail-done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = S_PREAMBLE;
            S_PREAMBLE: if (fall && pos_q == POS_W'(PRE_LEN - 1)) state_d = S_HEADER;
            S_HEADER:   if (fall && fidx == 5'(HDR_BITS - 1)) state_d = S_TURN;
            S_TURN:     if (fall && fidx == 5'(HDR_BITS + TA_BITS - 1)) state_d = S_DATA;
            S_DATA:     if (rise && last_bit) state_d = S_TAIL;
            S_TAIL:     if (fall) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Registered outputs and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            pos_q   <= '0;
            done_o  <= 1'b0;
            rdata_o <= '0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                frame_q <= frame_i;
                pos_q   <= '0;
            end else if (fall && state_q != S_IDLE && state_q != S_TAIL) begin
                pos_q   <= pos_q + POS_W'(1);
            end
            done_o <= rise && last_bit;
            if (rise && last_bit && rd)
                rdata_o <= {cap_q[DATA_BITS-2:0], mdio_i};
        end
    end

    // R7: an accepted start raises busy on the next cycle
    p_busy_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R8: done is a one-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done arrives while the frame still holds busy
    p_done_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R2: line data only moves while MDC is low
    p_mdio_moves_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$stable(mdio_o)) |-> !mdc_o);

    // R9: a start during a frame leaves the latched word alone
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(frame_q));

endmodule

// File: tb/mdio_frame_master_bench.sv
module mdio_frame_master_bench;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] frame_i = '0;
    logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rdata_o;
    logic        phy_drv = 1'b1;
    logic        mdio_line;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    assign mdio_line = mdio_oe_o ? mdio_o : phy_drv;

    mdio_frame_master #(.HALF_DIV(DIV), .PRE_LEN(32)) u_mdio_frame_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_line)
    );

    // Behavioural PHY and line monitor
    int          rcnt = 0;
    logic [63:0] rx_bits, oe_bits;
    logic        phy_rd = 1'b0;
    logic [15:0] phy_data = '0;

    always @(posedge mdc_o) begin
        if (rcnt < 64) begin
            rx_bits[63-rcnt] = mdio_line;
            oe_bits[63-rcnt] = mdio_oe_o;
        end
        rcnt = rcnt + 1;
    end

    always @(negedge mdc_o) begin
        if (phy_rd && rcnt == 47)                   phy_drv = 1'b0;
        else if (phy_rd && rcnt >= 48 && rcnt < 64) phy_drv = phy_data[63-rcnt];
        else                                        phy_drv = 1'b1;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Runs one frame; optionally injects a second start in mid-frame.
    task automatic run_frame(input logic [31:0] word, input logic [15:0] pdata,
                             input logic inject, input logic [15:0] old_rdata,
                             input string tag);
        int n = 0, done_at = -1, idle_at = -1, done_cnt = 0, mdc_hi = 0;
        logic [31:0] exp_word;
        logic [63:0] exp_oe;
        rcnt = 0; phy_rd = word[29]; phy_data = pdata;
        @(negedge clk); start_i = 1'b1; frame_i = word;
        @(negedge clk); start_i = 1'b0; frame_i = 32'h3FFF_FFFF;
        chk("R7", {tag, " busy after start"}, 64'(busy_o), 64'd1);
        while (n < 1000) begin
            if (inject && n == 40) start_i = 1'b1;
            if (inject && n == 41) start_i = 1'b0;
            if (done_o) begin
                done_cnt++;
                if (done_at < 0) done_at = n;
            end
            if (mdc_o) mdc_hi++;
            if (!busy_o) begin idle_at = n; break; end
            if (done_o) chk("R8", {tag, " busy high at done"}, 64'(busy_o), 64'd1);
            @(negedge clk); n++;
        end
        if (word[29]) begin
            exp_word = {word[31:18], 2'b10, pdata};
            exp_oe   = ~64'h3FFFF;
        end else begin
            exp_word = {word[31:18], 2'b10, word[15:0]};
            exp_oe   = '1;
        end
        chk("R3", {tag, " rising edges"}, 64'(rcnt), 64'd64);
        chk(word[29] ? "R5" : "R4", {tag, " line bits"}, rx_bits, {32'hFFFF_FFFF, exp_word});
        chk(word[29] ? "R5" : "R4", {tag, " drive enable"}, oe_bits, exp_oe);
        chk("R2", {tag, " MDC high clocks"}, 64'(mdc_hi), 64'(64*DIV));
        chk("R8", {tag, " done cycle"}, 64'(done_at), 64'(127*DIV));
        chk("R7", {tag, " busy low cycle"}, 64'(idle_at), 64'(128*DIV));
        chk("R6", {tag, " rdata"}, 64'(rdata_o), 64'(word[29] ? pdata : old_rdata));
        if (inject) chk("R9", {tag, " done pulses"}, 64'(done_cnt), 64'd1);
        chk("R1", {tag, " released when idle"}, {62'd0, mdio_oe_o, mdc_o}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R1", "reset busy", 64'(busy_o), 64'd0);
        chk("R1", "reset done", 64'(done_o), 64'd0);
        chk("R1", "reset mdc", 64'(mdc_o), 64'd0);
        chk("R1", "reset oe", 64'(mdio_oe_o), 64'd0);
    endtask

    task automatic t_address();   run_frame(32'h048E_C800, 16'h0, 1'b0, 16'h0, "address"); endtask
    task automatic t_read();      run_frame(32'h348E_ABCD, 16'h7FBF, 1'b0, 16'h0, "read"); endtask
    task automatic t_post_read(); run_frame(32'h2492_0000, 16'h8001, 1'b0, 16'h7FBF, "post-read"); endtask
    // TA bits in the word are 00; R4 requires 10 on the line
    task automatic t_write();     run_frame(32'h140C_0164, 16'hFFFF, 1'b0, 16'h8001, "write"); endtask
    task automatic t_busy_start(); run_frame(32'h0492_80C6, 16'h0, 1'b1, 16'h8001, "busy-start"); endtask

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_address();
        t_read();
        t_post_read();
        t_write();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule